// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank-State Checker

This block sits beside a four-bank synchronous DRAM interface as a passive observer. On every rising clock edge it takes in the clock enable, chip select, row strobe, column strobe, write enable, the bank-select bits and address bit 10. It reduces that cycle to a single command code and keeps an open/closed flag for each bank. Whenever a command arrives that does not fit the current state of its bank, or of all banks, it raises a one-cycle violation pulse with a reason code.

All outputs are registered. The command, bank, violation and reason seen after an edge describe the pins that edge captured. The open flags after that edge already include the effect of that command. The violation is judged against the bank state as it stood before the command. Data transfer, burst counting, refresh and every inter-command timing limit are left to other logic.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: While reset is held, and on the first edges after it is released, `cmd_o` is 0 (deselect), `bank_o` is 0, `bank_open_o` is all zero, and `viol_o` and `viol_rsn_o` are 0.
- R2: With clock enable high in both the current and the previous sampled cycle and `cs_n` high, the command code is 0 (deselect), whatever the other pins are.
- R3: With `cs_n` low, the bits {ras_n,cas_n,we_n} decode as follows: 111 gives 1 (no-op), 110 gives 2 (burst stop), 101 gives read, 100 gives write, 011 gives 7 (activate) and 010 gives precharge. Pattern 001 gives 11 (other).
- R4: When `cke` is low in the sampled cycle or in the cycle before it, the code is 12 (suspended) and no bank flag changes.
- R5: Address bit 10 picks the variant. A read gives 3 when `a10`=0 and 4 when `a10`=1. A write gives 5 or 6 in the same way. A precharge gives 8 (one bank) or 9 (all banks).
- R6: Activate (7) sets the flag of the bank on `ba`. Precharge (8) clears that one flag. Precharge-all (9) clears every flag.
- R7: A read or write with auto-precharge (4 or 6) leaves its bank closed after the command.
- R8: A read or write of any variant (3 to 6) aimed at a closed bank gives reason 1 (bank not open).
- R9: An activate aimed at an open bank gives reason 2 (bank already open).
- R10: Pattern 000 with `ba`=0 and `a10`=0 gives 10 (mode set). If any bank is open at that point, the reason is 3 (banks not idle). Pattern 000 with any other `ba` or `a10` gives 11.
- R11: Codes 0, 1, 2 and 11 change no bank flag.
- R12: `bank_o` carries the sampled bank bits. `viol_o` is high for exactly the cycles whose command broke a rule, and `viol_rsn_o` is 0 whenever `viol_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank-select bits |
| a10 | input | 1 | Address bit 10 (variant select) |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Sampled bank bits |
| bank_open_o | output | 4 | Open flag per bank |
| viol_o | output | 1 | Protocol violation pulse |
| viol_rsn_o | output | 2 | Violation reason code |

## Verification
The bench builds the block with its default of four banks. With that setting a two-bit random bank field reaches every bank within a handful of commands. Open/closed combinations then build up fast enough that rereads of closed banks, double activates, and mode sets with some or all banks open all occur many times in a few thousand cycles. Clock-enable gaps are drawn at random so that both the current-cycle and the previous-cycle suppression paths land on activates and precharges.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL  = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_BSTOP  = 4'd2,
    CMD_RD     = 4'd3,
    CMD_RDAP   = 4'd4,
    CMD_WR     = 4'd5,
    CMD_WRAP   = 4'd6,
    CMD_ACT    = 4'd7,
    CMD_PRE    = 4'd8,
    CMD_PREALL = 4'd9,
    CMD_MODE   = 4'd10,
    CMD_OTHER  = 4'd11,
    CMD_SUSP   = 4'd12
  } cmd_e;

  typedef enum logic [1:0] {
    RSN_NONE         = 2'd0,
    RSN_NOT_OPEN     = 2'd1,
    RSN_ALREADY_OPEN = 2'd2,
    RSN_BANKS_BUSY   = 2'd3
  } rsn_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output cmd_e            cmd
);

  logic cke_prev_q;
  logic cke_prev_d;

  // clock enable history, one cycle deep
  always_comb cke_prev_d = cke;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_prev_q <= 1'b0;
    else        cke_prev_q <= cke_prev_d;
  end

  always_comb begin
    cmd = CMD_OTHER;
    if (!cke || !cke_prev_q) begin
      cmd = CMD_SUSP;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b110:  cmd = CMD_BSTOP;
        3'b101:  cmd = a10 ? CMD_RDAP : CMD_RD;
        3'b100:  cmd = a10 ? CMD_WRAP : CMD_WR;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = a10 ? CMD_PREALL : CMD_PRE;
        3'b000:  cmd = ((ba == '0) && !a10) ? CMD_MODE : CMD_OTHER;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      bank,
  output logic [NUM_BANKS-1:0] open_q
);

  logic [NUM_BANKS-1:0] open_d;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    always_comb begin
      hit       = (bank == BA_W'(g));
      open_d[g] = open_q[g];
      unique case (cmd)
        CMD_ACT:                     if (hit) open_d[g] = 1'b1;
        CMD_PRE, CMD_RDAP, CMD_WRAP: if (hit) open_d[g] = 1'b0;
        CMD_PREALL:                  open_d[g] = 1'b0;
        default:                     open_d[g] = open_q[g];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q[g] <= 1'b0;
      else        open_q[g] <= open_d[g];
    end
  end

  a_r6_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |=> open_q[$past(bank)]);

  a_r6_preall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PREALL) |=> (open_q == '0));

  a_r7_autopre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RDAP || cmd == CMD_WRAP) |=> !open_q[$past(bank)]);

  a_r11_quiet_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DESEL || cmd == CMD_NOP || cmd == CMD_BSTOP ||
     cmd == CMD_OTHER || cmd == CMD_SUSP) |=> $stable(open_q));

endmodule

// File: rtl/sdram_viol_check.sv
module sdram_viol_check
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      bank,
  input  logic [NUM_BANKS-1:0] open_q,
  output rsn_e                 rsn
);

  logic target_open;
  logic any_open;

  always_comb begin
    target_open = open_q[bank];
    any_open    = |open_q;
    rsn         = RSN_NONE;
    unique case (cmd)
      CMD_RD, CMD_RDAP, CMD_WR, CMD_WRAP:
        if (!target_open) rsn = RSN_NOT_OPEN;
      CMD_ACT:
        if (target_open)  rsn = RSN_ALREADY_OPEN;
      CMD_MODE:
        if (any_open)     rsn = RSN_BANKS_BUSY;
      default:
        rsn = RSN_NONE;
    endcase
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output logic [3:0]           cmd_o,
  output logic [BA_W-1:0]      bank_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 viol_o,
  output logic [1:0]           viol_rsn_o
);

  // reset: asserted at once, released on the second clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  cmd_e cmd_now;
  rsn_e rsn_now;

  sdram_cmd_decode #(.BA_W(BA_W)) u_decode (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .a10   (a10),
    .cmd   (cmd_now)
  );

  sdram_bank_tracker #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_tracker (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd    (cmd_now),
    .bank   (ba),
    .open_q (bank_open_o)
  );

  sdram_viol_check #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_check (
    .cmd    (cmd_now),
    .bank   (ba),
    .open_q (bank_open_o),
    .rsn    (rsn_now)
  );

  logic [3:0]      cmd_d;
  logic [BA_W-1:0] bank_d;
  logic            viol_d;
  logic [1:0]      rsn_d;

  always_comb begin
    cmd_d  = cmd_now;
    bank_d = ba;
    rsn_d  = rsn_now;
    viol_d = (rsn_now != RSN_NONE);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_o      <= 4'(CMD_DESEL);
      bank_o     <= '0;
      viol_o     <= 1'b0;
      viol_rsn_o <= 2'(RSN_NONE);
    end else begin
      cmd_o      <= cmd_d;
      bank_o     <= bank_d;
      viol_o     <= viol_d;
      viol_rsn_o <= rsn_d;
    end
  end

  a_r4_susp_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cke |=> (cmd_o == 4'(CMD_SUSP)));

  a_r10_mode_clean_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_o == 4'(CMD_MODE) && viol_rsn_o == 2'(RSN_NONE)) |-> (bank_open_o == '0));

  a_r8_read_clean_open: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_o == 4'(CMD_RD) && viol_rsn_o == 2'(RSN_NONE)) |-> bank_open_o[bank_o]);

  a_r12_quiet_no_reason: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !viol_o |-> (viol_rsn_o == 2'(RSN_NONE)));

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic [3:0] cmd_o;
  logic [1:0] bank_o;
  logic [3:0] bank_open_o;
  logic       viol_o;
  logic [1:0] viol_rsn_o;

  int errors = 0;
  int checks = 0;

  // reference state
  logic [3:0] m_open;
  logic       m_ckep;

  always #2 clk = ~clk;

  sdram_cmd_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o),
    .bank_o(bank_o), .bank_open_o(bank_open_o), .viol_o(viol_o),
    .viol_rsn_o(viol_rsn_o)
  );

  function automatic logic [3:0] f_cmd(logic k, logic kp, logic c, logic r,
                                       logic ca, logic w, logic [1:0] b, logic a);
    if (!k || !kp) return 4'd12;
    if (c) return 4'd0;
    case ({r, ca, w})
      3'b111: return 4'd1;
      3'b110: return 4'd2;
      3'b101: return a ? 4'd4 : 4'd3;
      3'b100: return a ? 4'd6 : 4'd5;
      3'b011: return 4'd7;
      3'b010: return a ? 4'd9 : 4'd8;
      3'b000: return (b == 2'd0 && !a) ? 4'd10 : 4'd11;
      default: return 4'd11;
    endcase
  endfunction

  function automatic logic [1:0] f_rsn(logic [3:0] c, logic [1:0] b, logic [3:0] op);
    if (c >= 4'd3 && c <= 4'd6) return op[b] ? 2'd0 : 2'd1;
    if (c == 4'd7) return op[b] ? 2'd2 : 2'd0;
    if (c == 4'd10) return (op != 4'd0) ? 2'd3 : 2'd0;
    return 2'd0;
  endfunction

  function automatic logic [3:0] f_open(logic [3:0] c, logic [1:0] b, logic [3:0] op);
    logic [3:0] n = op;
    if (c == 4'd7) n[b] = 1'b1;
    if (c == 4'd8 || c == 4'd4 || c == 4'd6) n[b] = 1'b0;
    if (c == 4'd9) n = 4'd0;
    return n;
  endfunction

  function automatic string f_req(logic [3:0] c, logic [1:0] r);
    if (r == 2'd1) return "R8";
    if (r == 2'd2) return "R9";
    if (c == 4'd12) return "R4";
    if (c == 4'd0) return "R2";
    if (c == 4'd10 || r == 2'd3) return "R10";
    if (c == 4'd4 || c == 4'd6) return "R7";
    if (c == 4'd3 || c == 4'd5 || c == 4'd9) return "R5";
    if (c == 4'd7 || c == 4'd8) return "R6";
    if (c == 4'd11 || c == 4'd2) return "R11";
    return "R3";
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic step(input logic k, input logic c, input logic r, input logic ca,
                      input logic w, input logic [1:0] b, input logic a);
    logic [3:0] e_cmd, e_open;
    logic [1:0] e_rsn;
    string      req;
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; a10 = a;
    e_cmd  = f_cmd(k, m_ckep, c, r, ca, w, b, a);
    e_rsn  = f_rsn(e_cmd, b, m_open);
    e_open = f_open(e_cmd, b, m_open);
    req    = f_req(e_cmd, e_rsn);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (cmd_o !== e_cmd || bank_o !== b || viol_rsn_o !== e_rsn ||
        viol_o !== (e_rsn != 2'd0) || bank_open_o !== e_open) begin
      errors++;
      $display("FAIL %s (R12 outputs): cmd=%0d bank=%0d rsn=%0d viol=%0b open=%b expected cmd=%0d bank=%0d rsn=%0d viol=%0b open=%b",
               req, cmd_o, bank_o, viol_rsn_o, viol_o, bank_open_o,
               e_cmd, b, e_rsn, (e_rsn != 2'd0), e_open);
    end
    m_open = e_open;
    m_ckep = k;
  endtask

  task automatic nop();           step(1, 0, 1, 1, 1, 2'd0, 0); endtask
  task automatic act(input logic [1:0] b); step(1, 0, 0, 1, 1, b, 0); endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    m_open = 4'd0;
    m_ckep = 1'b1;
    rst_n = 1'b0;
    cke = 1; cs_n = 0; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; a10 = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (cmd_o !== 4'd0 || bank_o !== 2'd0 || bank_open_o !== 4'd0 ||
        viol_o !== 1'b0 || viol_rsn_o !== 2'd0) begin
      errors++;
      $display("FAIL R1: cmd=%0d bank=%0d open=%b viol=%0b rsn=%0d expected all zero",
               cmd_o, bank_o, bank_open_o, viol_o, viol_rsn_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (cmd_o !== 4'd1 || bank_open_o !== 4'd0 || viol_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: after release cmd=%0d open=%b viol=%0b expected 1 0000 0",
               cmd_o, bank_open_o, viol_o);
    end

    // directed corners
    step(1, 1, 0, 0, 0, 2'd3, 1);    // R2 deselect with other pins busy
    step(1, 0, 1, 0, 1, 2'd1, 0);    // R8 read of closed bank
    nop();                           // R12 pulse ends
    act(2'd1);                       // R6
    act(2'd1);                       // R9 double open
    step(1, 0, 1, 0, 1, 2'd1, 0);    // R5 plain read
    step(1, 0, 0, 0, 0, 2'd0, 0);    // R10 mode set with bank open
    step(1, 0, 0, 0, 0, 2'd2, 0);    // R10 malformed mode set gives other
    step(1, 0, 0, 0, 1, 2'd1, 0);    // R3 pattern 001 other, R11
    step(1, 0, 1, 1, 0, 2'd1, 0);    // R11 burst stop
    step(1, 0, 1, 0, 0, 2'd1, 1);    // R7 write with auto-precharge
    act(2'd0); act(2'd3);
    step(0, 0, 0, 1, 0, 2'd0, 1);    // R4 current-cycle gate on precharge-all
    step(1, 0, 0, 1, 0, 2'd0, 1);    // R4 previous-cycle gate
    step(1, 0, 0, 1, 0, 2'd3, 0);    // R6 single precharge
    step(1, 0, 0, 1, 0, 2'd0, 1);    // R5 precharge all
    step(1, 0, 0, 0, 0, 2'd0, 0);    // R10 clean mode set

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic k, c, r, ca, w, a;
      logic [1:0] b;
      k  = ($urandom_range(0, 15) != 0);
      c  = ($urandom_range(0, 7) == 0);
      r  = $urandom_range(0, 1);
      ca = $urandom_range(0, 1);
      w  = $urandom_range(0, 1);
      b  = 2'($urandom_range(0, 3));
      a  = ($urandom_range(0, 3) == 0);
      step(k, c, r, ca, w, b, a);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule